// File: doc/BRIEF.md
# Conditional Vector Writeback Gate

This block sits between a four-lane execution datapath and the register file. For every issued instruction it decides which of the four result components are actually written. A component is written only when its writemask bit is set and when a condition test passes. The test reads one stored condition code, and a per-slot swizzle chooses which stored code each destination component looks at. A 3-bit test code has one bit for each relation to zero that it accepts: less, equal and greater.

The block also owns the four-entry condition-code register. When an issued instruction asks for it, each lane of the final signed result is classified as negative, zero or positive. The classification is loaded into the register on the next clock edge. Instructions issued from that edge on test the new codes. A no-destination flag suppresses every register write but still allows the codes to be rewritten. This lets an instruction serve purely as a comparison.

Top module: `cond_wb_gate`

## Requirements
- R1: After reset every stored condition code reads "equal to zero" (code 1), so `cc_state` is 8'h55 and `wr_en` is 0 while nothing is issued.
- R2: While `issue_valid` is low, `wr_en` is 4'b0000 whatever the other inputs are.
- R3: For an issued instruction without `no_dest`, `wr_en[i]` equals `wr_mask[i]` AND bit c of `test_code`, where c is the stored code selected by slot i. This holds in the same cycle. Mask bit 0 is x and bit 3 is w.
- R4: Test code 7 passes every code, so `wr_en` equals `wr_mask`. Test code 0 passes none, so `wr_en` is 0. Codes 1 (LT), 2 (EQ), 3 (LE), 4 (GT), 5 (NE) and 6 (GE) accept exactly the relations whose bits they contain: bit 0 less, bit 1 equal, bit 2 greater.
- R5: Swizzle slot i occupies `cc_swz[2i+1:2i]`, and its value (0=x, 1=y, 2=z, 3=w) picks which stored code destination component i is tested against.
- R6: `no_dest` forces `wr_en` to 0. When `set_cc` is also given, the condition codes are still updated.
- R7: An issued instruction with `set_cc` loads the codes on the next edge. Lane i of `result` is `result[16i+15:16i]`, signed. It is stored in `cc_state[2i+1:2i]` as 0 when negative, 1 when zero and 2 when positive. The next instruction tests these new codes.
- R8: The condition codes hold their value when `set_cc` is low or when `issue_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| test_code | input | 3 | Condition test: bit0 less, bit1 equal, bit2 greater |
| cc_swz | input | 8 | Four 2-bit condition swizzle slots |
| wr_mask | input | 4 | Per-component writemask, x in bit 0 |
| set_cc | input | 1 | Update condition codes from this result |
| no_dest | input | 1 | Suppress all register writes |
| result | input | 64 | Four signed 16-bit result lanes |
| wr_en | output | 4 | Per-component register write enables |
| cc_state | output | 8 | Stored condition codes, 2 bits per lane |

## Verification
The bench covers each of the eight test codes against a mixed set of stored codes (negative, zero, positive). A design with a transposed relation bit would write a lane it should skip. Swizzles that steer every slot to one stored component are included, so a design that ignores the swizzle and tests lane i against code i gives the wrong pattern. Two kinds of instruction update the codes and are followed at once by a test: a no-destination comparison, and a back-to-back pair. A design that delays the update by a cycle, or that drops it under `no_dest`, is caught. Updates requested with `issue_valid` low are also driven, so a design that ignores the valid would corrupt the codes.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic [1:0] {
    CC_LT = 2'd0,
    CC_EQ = 2'd1,
    CC_GT = 2'd2
  } cc_code_e;

  localparam int CC_W = 2;

  // A test code accepts a relation when the bit at that relation's index is set.
  function automatic logic cc_accepts(input logic [2:0] test, input logic [CC_W-1:0] code);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (code == CC_W'(k)) hit = test[k];
    end
    return hit;
  endfunction
endpackage

// File: rtl/cwg_cc_reg.sv
module cwg_cc_reg
  import cwg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LANES*DATA_W-1:0] result,
  output logic [LANES*CC_W-1:0]   cc_flat
);
  function automatic logic [CC_W-1:0] classify(input logic [DATA_W-1:0] v);
    if (v[DATA_W-1])  return CC_LT;
    else if (v == '0) return CC_EQ;
    else              return CC_GT;
  endfunction

  logic [LANES*CC_W-1:0] cc_next;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign cc_next[i*CC_W +: CC_W] = classify(result[i*DATA_W +: DATA_W]);

      // R7
      cc_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_flat[i*CC_W +: CC_W] != 2'b11);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_flat <= {LANES{CC_W'(CC_EQ)}};
    else if (load) cc_flat <= cc_next;
  end

  // R8
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cc_flat));
endmodule

// File: rtl/cwg_lane_gate.sv
module cwg_lane_gate
  import cwg_pkg::*;
#(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [LANES*CC_W-1:0] cc_flat,
  input  logic [SEL_W-1:0]      sel,
  input  logic [2:0]            test,
  input  logic                  mask_bit,
  input  logic                  kill,
  output logic                  wen
);
  logic [CC_W-1:0] picked;
  logic            pass;

  always_comb begin
    picked = cc_flat[sel*CC_W +: CC_W];
    pass   = cc_accepts(test, picked);
    wen    = mask_bit & pass & ~kill;
  end
endmodule

// File: rtl/cond_wb_gate.sv
module cond_wb_gate
  import cwg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  input  logic [2:0]              test_code,
  input  logic [LANES*SEL_W-1:0]  cc_swz,
  input  logic [LANES-1:0]        wr_mask,
  input  logic                    set_cc,
  input  logic                    no_dest,
  input  logic [LANES*DATA_W-1:0] result,
  output logic [LANES-1:0]        wr_en,
  output logic [LANES*CC_W-1:0]   cc_state
);
  // Named internal events for the checks below.
  logic cc_update_ev;
  logic gate_kill;

  assign cc_update_ev = issue_valid & set_cc;
  assign gate_kill    = ~issue_valid | no_dest;

  cwg_cc_reg #(.LANES(LANES), .DATA_W(DATA_W)) u_cc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cc_update_ev),
    .result  (result),
    .cc_flat (cc_state)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_gate
      cwg_lane_gate #(.LANES(LANES)) u_gate (
        .cc_flat  (cc_state),
        .sel      (cc_swz[i*SEL_W +: SEL_W]),
        .test     (test_code),
        .mask_bit (wr_mask[i]),
        .kill     (gate_kill),
        .wen      (wr_en[i])
      );
    end
  endgenerate

  // R2
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> wr_en == '0);

  // R6
  no_dest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_dest |-> wr_en == '0);

  // R4
  always_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !no_dest && test_code == 3'd7) |-> wr_en == wr_mask);

  // R4
  never_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 3'd0) |-> wr_en == '0);

  // R3
  mask_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en & ~wr_mask) == '0);
endmodule

// File: tb/cond_wb_gate_test.sv
`timescale 1ns/1ps
module cond_wb_gate_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        issue_valid = 0;
  logic [2:0]  test_code = 0;
  logic [7:0]  cc_swz = 8'hE4;
  logic [3:0]  wr_mask = 0;
  logic        set_cc = 0;
  logic        no_dest = 0;
  logic [63:0] result = 0;
  logic [3:0]  wr_en;
  logic [7:0]  cc_state;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cond_wb_gate uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .test_code(test_code),
    .cc_swz(cc_swz), .wr_mask(wr_mask), .set_cc(set_cc), .no_dest(no_dest),
    .result(result), .wr_en(wr_en), .cc_state(cc_state)
  );

  typedef struct {
    logic [3:0] exp_wr;
    logic [7:0] exp_cc;
    string      tag;
  } item_t;

  item_t sb[$];
  logic [7:0] model_cc;

  function automatic logic [1:0] sign_code(input logic [15:0] v);
    if ($signed(v) < 0) return 2'd0;
    if (v == 16'd0)     return 2'd1;
    return 2'd2;
  endfunction

  function automatic bit relation_ok(input logic [2:0] t, input logic [1:0] c);
    case (c)
      2'd0: return (t == 3'd1 || t == 3'd3 || t == 3'd5 || t == 3'd7);
      2'd1: return (t == 3'd2 || t == 3'd3 || t == 3'd6 || t == 3'd7);
      2'd2: return (t == 3'd4 || t == 3'd5 || t == 3'd6 || t == 3'd7);
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit v, input logic [2:0] t, input logic [7:0] s,
                       input logic [3:0] m, input bit sc, input bit nd,
                       input logic [63:0] res, input string tag);
    item_t it;
    @(negedge clk);
    issue_valid = v; test_code = t; cc_swz = s; wr_mask = m;
    set_cc = sc; no_dest = nd; result = res;
    it.exp_wr = 4'b0;
    if (v && !nd)
      for (int i = 0; i < 4; i++)
        it.exp_wr[i] = m[i] && relation_ok(t, model_cc[2*s[2*i +: 2] +: 2]);
    it.exp_cc = model_cc;
    it.tag = tag;
    sb.push_back(it);
    if (v && sc)
      for (int i = 0; i < 4; i++) model_cc[2*i +: 2] = sign_code(res[16*i +: 16]);
  endtask

  // Monitor: pops one expectation per issued cycle, well before the next edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " wr_en"}, {4'b0, wr_en}, {4'b0, it.exp_wr});
        check({it.tag, " cc_state"}, cc_state, it.exp_cc);
      end
    end
  end

  localparam logic [7:0] ID = 8'hE4;
  // lanes w..x : -1, 5, 0, -3  -> codes x=LT y=EQ z=GT w=LT
  localparam logic [63:0] MIX = {16'hFFFF, 16'd5, 16'd0, 16'hFFFD};

  initial begin
    model_cc = 8'h55;
    #12;
    @(negedge clk);
    check("R1 reset cc", cc_state, 8'h55);
    check("R1 reset wr", {4'b0, wr_en}, 8'h00);
    rst_n = 1;

    issue(1, 3'd7, ID, 4'hF, 0, 0, 64'd0, "R4 always");
    issue(1, 3'd0, ID, 4'hF, 0, 0, 64'd0, "R4 never");
    issue(1, 3'd2, ID, 4'hF, 1, 0, MIX,   "R7 load from EQ state");
    issue(1, 3'd1, ID, 4'hF, 0, 0, 64'd0, "R3 LT");
    issue(1, 3'd2, ID, 4'hF, 0, 0, 64'd0, "R3 EQ");
    issue(1, 3'd3, ID, 4'hF, 0, 0, 64'd0, "R4 LE");
    issue(1, 3'd4, ID, 4'hF, 0, 0, 64'd0, "R4 GT");
    issue(1, 3'd5, ID, 4'hF, 0, 0, 64'd0, "R4 NE");
    issue(1, 3'd6, ID, 4'hF, 0, 0, 64'd0, "R4 GE");
    issue(1, 3'd7, ID, 4'b1010, 0, 0, 64'd0, "R3 partial mask");
    issue(1, 3'd4, 8'hAA, 4'hF, 0, 0, 64'd0, "R5 all slots z");
    issue(1, 3'd4, 8'h00, 4'hF, 0, 0, 64'd0, "R5 all slots x");
    issue(1, 3'd1, 8'h1B, 4'hF, 0, 0, 64'd0, "R5 reversed");
    issue(0, 3'd7, ID, 4'hF, 1, 0, 64'd0, "R2 R8 idle with set");
    issue(1, 3'd7, ID, 4'hF, 0, 0, 64'd7, "R8 no set");
    issue(1, 3'd7, ID, 4'hF, 1, 1, {16'd1, 16'hFF00, 16'd9, 16'd0}, "R6 no_dest compare");
    issue(1, 3'd4, ID, 4'hF, 1, 0, {16'd0, 16'd0, 16'h8000, 16'd3}, "R7 sees new codes");
    issue(1, 3'd2, ID, 4'hF, 0, 0, 64'd0, "R7 back to back");
    issue(0, 3'd0, ID, 4'h0, 0, 0, 64'd0, "R8 final hold");
    @(negedge clk);
    issue_valid = 0;
    @(negedge clk);
    @(negedge clk);
    finished = 1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule